// File: doc/BRIEF.md
# Single-precision to unsigned integer truncating converter

This block takes a 32-bit IEEE-754 single-precision operand with a valid strobe and returns a 32-bit unsigned integer, rounding toward zero. Any fractional part of the magnitude is dropped. The result appears one clock after the strobe, registered, together with an output valid.

Each operation raises at most one exception flag. The invalid flag covers these cases:
- every NaN, quiet or signalling;
- every negative value except negative zero, including negative values too small to survive truncation;
- every value of 2^32 or more, including positive infinity.

Inexact is raised only when no invalid condition exists and bits were discarded below the binary point. A registered status field records the flag of the latest operation and is cleared when that operation raised none.

The block sits behind an instruction decoder as the execution unit for a float-to-unsigned conversion. The status field is the per-operation exception record that the surrounding pipeline reads.

Top module: `f2u_trunc_conv`

## Requirements
- R1: A positive finite operand with value in [1.0, 2^32) gives the integer part of its value. When no fraction bits are dropped, neither flag is raised (for example 0x3F800000 gives 1 and 0x4F7FFFFF gives 0xFFFFFF00).
- R2: An operand with exponent field all ones and a nonzero mantissa (any NaN) gives 0 with invalid set.
- R3: An operand with the sign bit set that is not 0x80000000 gives 0 with invalid set. This includes negative infinity and tiny negatives such as 0x836D4E86.
- R4: Positive zero (0x00000000) and negative zero (0x80000000) give 0 with no flag.
- R5: A positive operand whose encoding is 0x4F800000 or above, including positive infinity 0x7F800000, gives 0xFFFFFFFF with invalid set.
- R6: When no invalid condition exists and the truncated result differs from the operand, inexact is set. Every positive nonzero value below 1.0, subnormals included, therefore gives 0 with inexact.
- R7: Invalid and inexact are never both set on one result.
- R8: Output valid is high exactly in the cycle after each cycle in which the input valid is high. The result and flags of that operation are presented in that cycle. Both flags are low whenever output valid is low.
- R9: The 2-bit status holds {invalid, inexact} (bit 1 invalid, bit 0 inexact) of the most recent operation. It is 00 when that operation raised no flag, and it holds its value in cycles with no output valid.
- R10: While reset is asserted, the result, both flags, output valid and status are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operand strobe |
| in_data | input | 32 | Single-precision operand |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_result | output | 32 | Unsigned truncated result |
| out_invalid | output | 1 | Invalid flag, qualified by out_valid |
| out_inexact | output | 1 | Inexact flag, qualified by out_valid |
| out_status | output | 2 | Last-operation flag record {invalid, inexact} |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid latency and that the flags are qualified by output valid;
- that the two flags are mutually exclusive;
- that the status mirrors the flags and holds between operations;
- that NaN, negative nonzero, saturating, zero and below-one operands each map to their fixed result and flag.

Only the bench scenarios can show the truncated integer value across the exponent range and the inexact decision for in-range values. They also cover the boundary encodings, such as the largest value below 2^32 and values near 2^23, and the clearing effect of a reset in mid-run.

// File: rtl/f2u_pkg.sv
package f2u_pkg;
  // Operand category, decided before any rounding takes place.
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,  // +0 or -0: result 0, no flag
    CLS_NAN  = 3'd1,  // any NaN: result 0, invalid
    CLS_NEG  = 3'd2,  // negative nonzero: result 0, invalid
    CLS_OVF  = 3'd3,  // >= 2^INT_W: saturate, invalid
    CLS_FRAC = 3'd4,  // positive nonzero below 1.0: result 0, inexact
    CLS_INT  = 3'd5   // positive in [1, 2^INT_W): shifted mantissa
  } f2u_class_e;
endpackage

// File: rtl/f2u_classify.sv
module f2u_classify
  import f2u_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32
) (
  input  logic [EXP_W+MAN_W:0]       op,
  output f2u_class_e                 cls,
  output logic [$clog2(INT_W)-1:0]   shamt
);
  localparam int SH_W    = $clog2(INT_W);
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int OVF_EXP = BIAS + INT_W;
  localparam logic [EXP_W-1:0] EXP_ONES = {EXP_W{1'b1}};
  localparam logic [EXP_W-1:0] EXP_OVF  = EXP_W'(OVF_EXP);
  localparam logic [EXP_W-1:0] EXP_ONE  = EXP_W'(BIAS);
  localparam logic [SH_W-1:0]  BIAS_LO  = SH_W'(BIAS);

  logic             sgn;
  logic [EXP_W-1:0] expf;
  logic [MAN_W-1:0] manf;
  logic             man_nz;
  logic             exp_nz;

  assign sgn    = op[EXP_W+MAN_W];
  assign expf   = op[MAN_W +: EXP_W];
  assign manf   = op[MAN_W-1:0];
  assign man_nz = |manf;
  assign exp_nz = |expf;

  // Priority: NaN, then sign, then magnitude range.
  always_comb begin
    if ((expf == EXP_ONES) && man_nz)      cls = CLS_NAN;
    else if (sgn && (exp_nz || man_nz))    cls = CLS_NEG;
    else if (sgn)                          cls = CLS_ZERO;
    else if (expf >= EXP_OVF)              cls = CLS_OVF;
    else if (expf < EXP_ONE)               cls = (exp_nz || man_nz) ? CLS_FRAC : CLS_ZERO;
    else                                   cls = CLS_INT;
  end

  // Unbiased exponent, meaningful only in CLS_INT where it lies in [0, INT_W).
  assign shamt = expf[SH_W-1:0] - BIAS_LO;
endmodule

// File: rtl/f2u_align.sv
module f2u_align #(
  parameter int MAN_W = 23,
  parameter int INT_W = 32
) (
  input  logic [MAN_W-1:0]           man,
  input  logic [$clog2(INT_W)-1:0]   shamt,
  output logic [INT_W-1:0]           int_part,
  output logic                       frac_nz
);
  localparam int SH_W = $clog2(INT_W);
  localparam int W    = INT_W + MAN_W;

  logic [W-1:0] stg [0:SH_W];

  // Significand with hidden one, binary point sits above bit MAN_W-1.
  assign stg[0] = {{(INT_W-1){1'b0}}, 1'b1, man};

  for (genvar i = 0; i < SH_W; i++) begin : g_stage
    assign stg[i+1] = shamt[i] ? (stg[i] << (1 << i)) : stg[i];
  end

  assign int_part = stg[SH_W][W-1:MAN_W];
  assign frac_nz  = |stg[SH_W][MAN_W-1:0];
endmodule

// File: rtl/f2u_resolve.sv
module f2u_resolve
  import f2u_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  f2u_class_e        cls,
  input  logic [INT_W-1:0]  int_part,
  input  logic              frac_nz,
  output logic [INT_W-1:0]  result,
  output logic              invalid,
  output logic              inexact
);
  // One flag per operation: invalid paths never raise inexact.
  always_comb begin
    result  = '0;
    invalid = 1'b0;
    inexact = 1'b0;
    case (cls)
      CLS_NAN, CLS_NEG: invalid = 1'b1;
      CLS_OVF: begin
        result  = '1;
        invalid = 1'b1;
      end
      CLS_FRAC: inexact = 1'b1;
      CLS_INT: begin
        result  = int_part;
        inexact = frac_nz;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/f2u_trunc_conv.sv
module f2u_trunc_conv
  import f2u_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [EXP_W+MAN_W:0]   in_data,
  output logic                   out_valid,
  output logic [INT_W-1:0]       out_result,
  output logic                   out_invalid,
  output logic                   out_inexact,
  output logic [1:0]             out_status
);
  localparam int SH_W = $clog2(INT_W);

  f2u_class_e        cls;
  logic [SH_W-1:0]   shamt;
  logic [INT_W-1:0]  int_part;
  logic              frac_nz;
  logic [INT_W-1:0]  res_c;
  logic              inv_c;
  logic              inx_c;

  f2u_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_classify (
    .op    (in_data),
    .cls   (cls),
    .shamt (shamt)
  );

  f2u_align #(.MAN_W(MAN_W), .INT_W(INT_W)) u_align (
    .man      (in_data[MAN_W-1:0]),
    .shamt    (shamt),
    .int_part (int_part),
    .frac_nz  (frac_nz)
  );

  f2u_resolve #(.INT_W(INT_W)) u_resolve (
    .cls      (cls),
    .int_part (int_part),
    .frac_nz  (frac_nz),
    .result   (res_c),
    .invalid  (inv_c),
    .inexact  (inx_c)
  );

  // Next-state logic
  logic              cap_en;
  logic              vld_d,  vld_q;
  logic [INT_W-1:0]  res_d,  res_q;
  logic              inv_d,  inv_q;
  logic              inx_d,  inx_q;
  logic [1:0]        sts_d,  sts_q;

  assign cap_en = in_valid;

  always_comb begin
    vld_d = in_valid;
    inv_d = in_valid & inv_c;
    inx_d = in_valid & inx_c;
    res_d = res_q;
    sts_d = sts_q;
    if (cap_en) begin
      res_d = res_c;
      sts_d = {inv_c, inx_c};
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      inv_q <= 1'b0;
      inx_q <= 1'b0;
      sts_q <= 2'b00;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
      inv_q <= inv_d;
      inx_q <= inx_d;
      sts_q <= sts_d;
    end
  end

  assign out_valid   = vld_q;
  assign out_result  = res_q;
  assign out_invalid = inv_q;
  assign out_inexact = inx_q;
  assign out_status  = sts_q;
endmodule

// File: rtl/f2u_checker.sv
module f2u_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_data,
  input logic        out_valid,
  input logic [31:0] out_result,
  input logic        out_invalid,
  input logic        out_inexact,
  input logic [1:0]  out_status
);
  logic op_nan, op_neg_nz, op_big, op_zero, op_small;
  assign op_nan    = (in_data[30:23] == 8'hFF) && (in_data[22:0] != 23'd0);
  assign op_neg_nz = in_data[31] && (in_data[30:0] != 31'd0) && !op_nan;
  assign op_big    = !in_data[31] && (in_data[30:0] >= 31'h4F800000) && !op_nan;
  assign op_zero   = (in_data[30:0] == 31'd0);
  assign op_small  = !in_data[31] && (in_data[30:0] != 31'd0) && (in_data[30:23] < 8'd127);

  assert_nan_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_nan) |=> (out_result == 32'd0 && out_invalid && !out_inexact));

  assert_negative_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_neg_nz) |=> (out_result == 32'd0 && out_invalid && !out_inexact));

  assert_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_zero) |=> (out_result == 32'd0 && !out_invalid && !out_inexact));

  assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_big) |=> (out_result == 32'hFFFFFFFF && out_invalid && !out_inexact));

  assert_below_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_small) |=> (out_result == 32'd0 && out_inexact && !out_invalid));

  assert_one_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_invalid && out_inexact));

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_flag_qual_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_invalid || out_inexact) |-> out_valid);

  assert_status_mirror_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_status == {out_invalid, out_inexact}));

  assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_status));
endmodule

bind f2u_trunc_conv f2u_checker i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_data     (in_data),
  .out_valid   (out_valid),
  .out_result  (out_result),
  .out_invalid (out_invalid),
  .out_inexact (out_inexact),
  .out_status  (out_status)
);

// File: tb/test_f2u_trunc_conv.sv
module test_f2u_trunc_conv;
  localparam time CLK_PERIOD = 10ns;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_data;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_invalid;
  logic        out_inexact;
  logic [1:0]  out_status;

  int n_checks = 0;
  int n_fail   = 0;
  logic [33:0] q_exp[$];
  string       q_tag[$];
  logic [1:0]  last_status;
  logic        mon_en;

  f2u_trunc_conv i_f2u_trunc_conv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_result(out_result), .out_invalid(out_invalid),
    .out_inexact(out_inexact), .out_status(out_status)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // Reference model built from the requirements: {result, invalid, inexact}.
  function automatic logic [33:0] model(input logic [31:0] x, output string tag);
    logic [7:0]  e;
    logic [63:0] sig;
    logic [63:0] r;
    int          p;
    logic        inx;
    e = x[30:23];
    if (e == 8'hFF && x[22:0] != 0) begin tag = "R2"; return {32'd0, 2'b10}; end
    if (x == 32'h80000000)           begin tag = "R4"; return {32'd0, 2'b00}; end
    if (x[31])                       begin tag = "R3"; return {32'd0, 2'b10}; end
    if (x == 32'd0)                  begin tag = "R4"; return {32'd0, 2'b00}; end
    if (x >= 32'h4F800000)           begin tag = "R5"; return {32'hFFFFFFFF, 2'b10}; end
    sig = (e == 0) ? {41'd0, x[22:0]} : {40'd0, 1'b1, x[22:0]};
    p = (e == 0) ? -149 : int'(e) - 150;
    if (p >= 0) begin
      r = sig << p; inx = 1'b0;
    end else if (p <= -25) begin
      r = 0; inx = 1'b1;
    end else begin
      r = sig >> (-p);
      inx = ((r << (-p)) != sig);
    end
    tag = (e < 8'd127 || inx) ? "R6" : "R1";
    return {r[31:0], 1'b0, inx};
  endfunction

  task automatic drive(input logic [31:0] x);
    string t;
    logic [33:0] m;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = x;
    m = model(x, t);
    q_exp.push_back(m);
    q_tag.push_back(t);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 32'hDEADBEEF;
    end
  endtask

  // Monitor / scoreboard
  initial begin
    last_status = 2'b00;
    forever begin
      @(negedge clk);
      if (rst_n && mon_en) begin
        if (out_valid) begin
          logic [33:0] e;
          string t;
          if (q_exp.size() == 0) begin
            check(1'b0, "R8", "valid with no pending operation", 64'(out_valid), 64'd0);
          end else begin
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            check({out_result, out_invalid, out_inexact} == e, t, "result/flags",
                  64'({out_result, out_invalid, out_inexact}), 64'(e));
            check(!(out_invalid && out_inexact), "R7", "both flags set",
                  64'({out_invalid, out_inexact}), 64'd0);
            check(out_status == e[1:0], "R9", "status after operation",
                  64'(out_status), 64'(e[1:0]));
            last_status = e[1:0];
          end
        end else begin
          check(!out_invalid && !out_inexact, "R8", "flag without valid",
                64'({out_invalid, out_inexact}), 64'd0);
          check(out_status == last_status, "R9", "status hold when idle",
                64'(out_status), 64'(last_status));
        end
      end
    end
  end

  task automatic check_reset_state();
    check(out_valid == 0 && out_result == 0 && out_invalid == 0 &&
          out_inexact == 0 && out_status == 0, "R10", "outputs in reset",
          64'({out_valid, out_result, out_invalid, out_inexact, out_status}), 64'd0);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R8 watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    mon_en   = 1'b0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = 32'd0;
    repeat (3) @(negedge clk);
    check_reset_state();                // R10 initial reset
    rst_n  = 1'b1;
    mon_en = 1'b1;
    idle(2);

    // R1 exact integers and boundaries
    drive(32'h3F800000);   // 1.0 -> 1
    drive(32'h4F7FFFFF);   // largest below 2^32 -> 0xFFFFFF00
    drive(32'h4B000001);   // 2^23+1
    drive(32'h4B7FFFFF);   // 2^24-1
    drive(32'h4E800000);   // 2^30
    // R6 inexact
    drive(32'h3FC00000);   // 1.5 -> 1
    drive(32'h3F000000);   // 0.5 -> 0
    drive(32'h00000001);   // smallest subnormal
    drive(32'h3F7FFFFF);   // just below 1.0
    drive(32'h4AFFFFFF);   // 8388607.5
    idle(2);
    // R2 NaNs
    drive(32'h7FC00000);
    drive(32'h7F800001);
    drive(32'hFFFFFFFF);
    idle(1);
    // R3 negatives
    drive(32'h836D4E86);
    drive(32'hFF800000);
    drive(32'hBF800000);
    drive(32'h80000001);
    // R4 zeros
    drive(32'h80000000);
    drive(32'h00000000);
    idle(3);
    // R5 saturation
    drive(32'h4F800000);
    drive(32'h7F800000);
    drive(32'h7F7FFFFF);
    idle(2);

    // Mixed random traffic with gaps
    lfsr = 32'h1234ABCD;
    for (int i = 0; i < 400; i++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      if (lfsr[0] && lfsr[1]) idle(1);
      else if (lfsr[2]) drive({lfsr[31], 1'b1, lfsr[29:0] ^ {lfsr[3], 29'd0}} ^ 32'h30000000);
      else drive(lfsr);
    end
    idle(3);
    check(q_exp.size() == 0, "R8", "pending results after drain",
          64'(q_exp.size()), 64'd0);

    // Leave a flag in status, then reset mid-run
    drive(32'h7FC00000);
    idle(2);
    @(negedge clk);
    mon_en = 1'b0;
    rst_n  = 1'b0;
    @(negedge clk);
    check_reset_state();                // R10 mid-run reset
    rst_n = 1'b1;
    last_status = 2'b00;
    mon_en = 1'b1;
    idle(2);
    drive(32'h41200000);   // 10.0 -> 10
    idle(3);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule